// File: doc/BRIEF.md
# Serial Peripheral Interface Engine

This block moves one character of 4 to 16 bits at a time over a four-wire synchronous serial link. It can act as the master, in which case it drives the serial clock, the outgoing data line and an active-low select. It can also act as a slave. As a slave it follows an external serial clock and drives its outgoing data line only while it is selected. Software sets it up through a 16-bit mode word on a small register bus. Writing the transmit word starts a character, and the block raises a completion flag once it has sampled the last bit.

The mode word sets the idle level of the clock and the edge order of each bit. It sets the character length and the master bit rate. As a master, the bit rate comes from the system clock, either directly or through a fixed divide-by-16 stage. The mode word also selects an internal loopback, which feeds the block's own outgoing bits into its receiver. In loopback the bit sequencing runs as usual, but the captured character is thrown away.

Top module: `spi_engine`

## Requirements
- R1: After reset the mode word is zero. The block is then a disabled slave: all three output enables are low, `sck_o` is 0, `ss_n_o` is 1, `done` is 0 and `rx_data` is 0.
- R2: Bus writes with `reg_addr`=0 load the mode word. Its bits are: bit 14 loopback, bit 13 clock idle level, bit 12 phase, bit 11 divide-by-16, bit 9 master (1) or slave (0), bit 8 enable, bits 7:4 length code, bits 3:0 rate code. Writes with `reg_addr`=1 load the transmit word. Any mode write abandons a character in progress.
- R3: Whenever no character is in progress, the serial clock sits at the idle level given by mode bit 13.
- R4: As a master, each half bit period lasts 2*(rate+1) input ticks. An input tick is one system clock, or 16 system clocks when bit 11 is set, so a full bit takes 4*(rate+1) ticks.
- R5: A character has length code + 1 bits. Any code below 3 gives 4 bits. Bits go out most significant bit first, taken from the low bits of the transmit word.
- R6: With phase 0, the first bit is on the data line before the first clock edge. Data is sampled on each leading edge (the edge leaving the idle level) and changes on each trailing edge.
- R7: With phase 1, data changes on each leading edge after the first and is sampled on each trailing edge.
- R8: When the last bit is sampled, `done` rises and `rx_data` takes the received character, right-aligned. `done` stays high until the next accepted transmit write clears it.
- R9: In loopback, the received bits are ignored. `rx_data` keeps its old value while `done` still rises.
- R10: As a slave, bit timing comes from `sck_i` and bit 11 has no effect. `miso_oe` is high only while enabled and `ss_n_i` is low. The block never enables `miso_o` and `mosi_o` at the same time.
- R11: With enable clear, transmit writes are ignored: no clock edges occur, `busy` stays low and `done` keeps its value.
- R12: Bits 15 and 10 of the mode word are reserved and have no effect on behaviour.
- R13: As a master, `ss_n_o` is low exactly while a character is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the master bit-rate source |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the mode word, 1 the transmit word |
| reg_wdata | input | 16 | Write data |
| rx_data | output | 16 | Last character received, right-aligned |
| done | output | 1 | Character complete flag |
| busy | output | 1 | A character is in progress |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock in (slave) |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | Master data output enable |
| mosi_i | input | 1 | Master data in (slave receive) |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Slave data output enable |
| miso_i | input | 1 | Slave data in (master receive) |
| ss_n_o | output | 1 | Select out, active low (master) |
| ss_n_i | input | 1 | Select in, active low (slave) |

## Verification
The hardest case to reach is phase 1 as a slave. There the first leading edge must not shift, while the captured bit comes from a line the bench itself drives through a synchronizer. The bench acts as an external master that changes `mosi_i` on leading edges and holds each clock level for eight system clocks, well beyond the synchronizer delay. It reads `miso_o` just before each trailing edge, so any off-by-one shift shows up in the captured word. Loopback is reached by first receiving a known character in normal mode, then running a character with different incoming data; the earlier value must survive.

// File: rtl/spi_engine.sv
module spi_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] rx_data,
  output logic        done,
  output logic        busy,
  output logic        sck_o,
  output logic        sck_oe,
  input  logic        sck_i,
  output logic        mosi_o,
  output logic        mosi_oe,
  input  logic        mosi_i,
  output logic        miso_o,
  output logic        miso_oe,
  input  logic        miso_i,
  output logic        ss_n_o,
  input  logic        ss_n_i
);
  logic loop_m, ci, cp, d16, mst, en;
  logic [3:0] cl, pm;
  logic [15:0] sh;
  logic [14:0] rsh;
  logic [3:0] pre;
  logic [4:0] div, bcnt;
  logic act, sck_q, first;
  logic [2:0] sck_sy;
  logic [1:0] ss_sy, mosi_sy;

  wire wr_mode = reg_wr & ~reg_addr;
  wire wr_tx   = reg_wr & reg_addr & en;
  wire [4:0] len = (cl < 4'd3) ? 5'd4 : {1'b0, cl} + 5'd1;

  wire btick  = ~d16 | (pre == 4'hF);
  wire m_edge = mst & act & btick & (div == {pm, 1'b1});
  wire s_edge = ~mst & act & ~ss_sy[1] & (sck_sy[2] ^ sck_sy[1]);
  wire edg    = m_edge | s_edge;
  wire at_idle = mst ? ~sck_q : ~(sck_sy[2] ^ ci);
  wire lead   = edg & at_idle;
  wire trail  = edg & ~at_idle;
  wire samp   = cp ? trail : lead;
  wire shft   = cp ? (lead & ~first) : trail;
  wire din    = loop_m ? sh[15] : (mst ? miso_i : mosi_sy[1]);
  wire last   = samp & (bcnt == len - 5'd1);
  wire fin    = mst ? (trail & (cp ? last : (bcnt == len))) : last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {loop_m, ci, cp, d16, mst, en} <= '0;
      cl <= '0;
      pm <= '0;
    end else if (wr_mode) begin
      {loop_m, ci, cp, d16} <= reg_wdata[14:11];
      {mst, en} <= reg_wdata[9:8];
      cl <= reg_wdata[7:4];
      pm <= reg_wdata[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy  <= '0;
      ss_sy   <= '1;
      mosi_sy <= '0;
    end else begin
      sck_sy  <= {sck_sy[1:0], sck_i};
      ss_sy   <= {ss_sy[0], ss_n_i};
      mosi_sy <= {mosi_sy[0], mosi_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0; sck_q <= 1'b0; first <= 1'b0;
      pre <= '0; div <= '0; bcnt <= '0;
      sh <= '0; rsh <= '0; rx_data <= '0; done <= 1'b0;
    end else if (wr_mode) begin
      act <= 1'b0; sck_q <= 1'b0;
    end else if (wr_tx) begin
      act <= 1'b1; sck_q <= 1'b0; first <= 1'b1;
      pre <= '0; div <= '0; bcnt <= '0;
      sh <= reg_wdata << (5'd16 - len);
      rsh <= '0;
      done <= 1'b0;
    end else if (act) begin
      pre <= pre + 4'd1;
      if (btick) div <= (div == {pm, 1'b1}) ? 5'd0 : div + 5'd1;
      if (m_edge) sck_q <= ~sck_q;
      if (lead) first <= 1'b0;
      if (shft) sh <= {sh[14:0], 1'b0};
      if (samp) begin
        rsh <= {rsh[13:0], din};
        bcnt <= bcnt + 5'd1;
      end
      if (last) begin
        done <= 1'b1;
        if (!loop_m) rx_data <= {rsh, din};
      end
      if (fin) act <= 1'b0;
    end
  end

  assign busy    = act;
  assign sck_o   = sck_q ^ ci;
  assign sck_oe  = mst & en;
  assign mosi_o  = sh[15];
  assign mosi_oe = mst & en;
  assign miso_o  = sh[15];
  assign miso_oe = ~mst & en & ~ss_sy[1];
  assign ss_n_o  = ~(mst & act);
endmodule

module spi_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        ci,
  input logic        en,
  input logic        loop_m,
  input logic        busy,
  input logic        sck_o,
  input logic        sck_oe,
  input logic        mosi_oe,
  input logic        miso_oe,
  input logic        ss_n_o,
  input logic        done,
  input logic [15:0] rx_data
);
  // R3
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && sck_oe) |-> (sck_o == ci));
  // R13
  ss_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mosi_oe) |-> !ss_n_o);
  // R10
  drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(miso_oe && mosi_oe));
  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !reg_wr) |=> done);
  // R9
  loop_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_m |=> $stable(rx_data));
  // R11
  en_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !busy);
endmodule

bind spi_engine spi_engine_chk u_chk (.*);

// File: tb/tb_spi_engine.sv
module tb_spi_engine;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_addr = 0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] rx_data;
  logic done, busy, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_n_o;
  logic sck_i = 0, mosi_i = 0, miso_i = 0, ss_n_i = 1;

  spi_engine dut (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] exp_q[$];
  logic [15:0] rx_model = '0;
  logic done_d = 0;

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor: pops an expected character whenever done rises
  always @(negedge clk) begin
    if (rst_n && done && !done_d) begin
      if (exp_q.size() == 0) check(0, "R8 unexpected done", rx_data, 16'h0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(rx_data == e, "R8/R9 rx_data", rx_data, e);
      end
    end
    done_d <= done;
  end

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  function automatic logic [15:0] mk(input logic lp, c_i, c_p, dv, ms, e, input logic [3:0] c_l, p_m);
    return {1'b0, lp, c_i, c_p, dv, 1'b0, ms, e, c_l, p_m};
  endfunction

  function automatic int clen(input logic [3:0] c_l);
    return (c_l < 3) ? 4 : int'(c_l) + 1;
  endfunction

  task automatic run_master(input logic lp, c_i, c_p, dv, input logic [3:0] c_l, p_m,
                            input logic [15:0] txw, inw, rsv);
    int len, lead_n, k, cyc, last_e, nedge, half;
    logic prev;
    logic [15:0] mw, cap, mask, e;
    len = clen(c_l);
    mask = 16'hFFFF >> (16 - len);
    mw = inw << (16 - len);
    half = 2 * (int'(p_m) + 1) * (dv ? 16 : 1);
    wr(0, mk(lp, c_i, c_p, dv, 1, 1, c_l, p_m) | rsv);
    check(sck_o == c_i, "R3 idle level", {15'd0, sck_o}, {15'd0, c_i});
    e = lp ? rx_model : (inw & mask);
    if (!lp) rx_model = e;
    exp_q.push_back(e);
    miso_i = mw[15];
    cap = '0; lead_n = 0; k = 0; cyc = 0; last_e = 0; nedge = 0;
    prev = c_i;
    wr(1, txw);
    check(done == 0, "R8 done cleared by write", {15'd0, done}, 16'd0);
    check(ss_n_o == 0, "R13 select low", {15'd0, ss_n_o}, 16'd0);
    while (!ss_n_o && cyc < 40000) begin
      @(negedge clk);
      cyc++;
      if (sck_o != prev) begin
        nedge++;
        if (nedge == 2) check(cyc - last_e == half, "R4 half period", 16'(cyc - last_e), 16'(half));
        last_e = cyc;
        if (prev == c_i) begin
          if (c_p) begin
            if (lead_n < len) miso_i = mw[15 - lead_n];
            lead_n++;
          end else cap = {cap[14:0], mosi_o};
        end else begin
          if (c_p) cap = {cap[14:0], mosi_o};
          else begin
            k++;
            if (k < len) miso_i = mw[15 - k];
          end
        end
        prev = sck_o;
      end
    end
    check(nedge == 2 * len, "R5 edge count", 16'(nedge), 16'(2 * len));
    check((cap & mask) == (txw & mask), "R5/R6/R7 mosi bits", cap & mask, txw & mask);
    check(sck_o == c_i, "R3 idle after", {15'd0, sck_o}, {15'd0, c_i});
    repeat (3) @(negedge clk);
  endtask

  task automatic run_slave(input logic lp, c_i, c_p, dv, input logic [3:0] c_l,
                           input logic [15:0] txw, inw);
    int len;
    logic [15:0] mw, cap, mask, e;
    len = clen(c_l);
    mask = 16'hFFFF >> (16 - len);
    mw = inw << (16 - len);
    sck_i = c_i; ss_n_i = 1;
    wr(0, mk(lp, c_i, c_p, dv, 0, 1, c_l, 4'd0));
    e = lp ? rx_model : (inw & mask);
    if (!lp) rx_model = e;
    exp_q.push_back(e);
    wr(1, txw);
    repeat (4) @(negedge clk);
    check(miso_oe == 0, "R10 miso off while deselected", {15'd0, miso_oe}, 16'd0);
    ss_n_i = 0;
    mosi_i = mw[15];
    repeat (8) @(negedge clk);
    check(miso_oe == 1, "R10 miso on while selected", {15'd0, miso_oe}, 16'd1);
    cap = '0;
    for (int i = 0; i < len; i++) begin
      if (c_p) begin
        sck_i = ~c_i; mosi_i = mw[15 - i];
        repeat (8) @(negedge clk);
        cap = {cap[14:0], miso_o};
        sck_i = c_i;
        repeat (8) @(negedge clk);
      end else begin
        mosi_i = mw[15 - i];
        repeat (8) @(negedge clk);
        cap = {cap[14:0], miso_o};
        sck_i = ~c_i;
        repeat (8) @(negedge clk);
        sck_i = c_i;
        repeat (8) @(negedge clk);
      end
    end
    check((cap & mask) == (txw & mask), "R10/R6/R7 miso bits", cap & mask, txw & mask);
    check(done == 1, "R8 slave done", {15'd0, done}, 16'd1);
    ss_n_i = 1;
    repeat (6) @(negedge clk);
    check(miso_oe == 0, "R10 miso released", {15'd0, miso_oe}, 16'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 16'd0, 16'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check({sck_oe, mosi_oe, miso_oe} == 3'b000, "R1 enables", {13'd0, sck_oe, mosi_oe, miso_oe}, 16'd0);
    check(sck_o == 0 && ss_n_o == 1 && done == 0, "R1 pins", {13'd0, sck_o, ss_n_o, done}, 16'h2);
    check(rx_data == 0, "R1 rx_data", rx_data, 16'd0);

    // R2 R5 R6 master, phase 0, idle low, 8 bits
    run_master(0, 0, 0, 0, 4'd7, 4'd1, 16'h00A5, 16'h003C, 16'h0);
    // R7 R3 phase 1, idle high, 16 bits
    run_master(0, 1, 1, 0, 4'd15, 4'd0, 16'hC3A1, 16'h5E17, 16'h0);
    // R4 divide-by-16
    run_master(0, 0, 1, 1, 4'd5, 4'd1, 16'h002D, 16'h0012, 16'h0);
    // R5 short length code -> 4 bits
    run_master(0, 1, 0, 0, 4'd1, 4'd2, 16'hFFF9, 16'h0006, 16'h0);
    // R12 reserved bits set
    run_master(0, 0, 0, 0, 4'd11, 4'd3, 16'h0B6D, 16'h0492, 16'h8400);
    // R9 loopback keeps rx_data
    run_master(1, 0, 1, 0, 4'd7, 4'd0, 16'h0081, 16'h00FF, 16'h0);
    check(rx_data == rx_model, "R9 rx_data kept", rx_data, rx_model);

    // R11 enable clear
    wr(0, mk(0, 0, 0, 0, 1, 0, 4'd7, 4'd0));
    wr(1, 16'h00AA);
    repeat (100) @(negedge clk);
    check(busy == 0 && ss_n_o == 1, "R11 no start", {14'd0, busy, ss_n_o}, 16'd1);
    check(done == 1, "R11 done kept", {15'd0, done}, 16'd1);
    check(sck_o == 0, "R11 clock idle", {15'd0, sck_o}, 16'd0);

    // R10 slave modes, divide-by-16 set has no effect
    run_slave(0, 0, 0, 0, 4'd7, 16'h0069, 16'h00B4);
    run_slave(0, 1, 1, 1, 4'd9, 16'h02C7, 16'h0158);
    run_slave(1, 0, 1, 0, 4'd3, 16'h000A, 16'h0005);
    check(rx_data == rx_model, "R9 slave loopback", rx_data, rx_model);

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R8 all characters seen", 16'(exp_q.size()), 16'd0);
    finish_run();
  end
endmodule